// File: doc/BRIEF.md
# Memory Access Permission Fault Checker

This block sits after an address translation stage and decides whether an access that has already found its descriptor may go ahead. It takes the two-bit access value of the descriptor's domain, the descriptor word itself (a one-megabyte section or a small page), the two global protection control bits, whether the processor is in user or privileged mode, and whether the access is a read, a write or an instruction fetch. It classifies the access as allowed, a domain fault, a permission fault or a translation fault (no descriptor).

The decision is registered. One cycle after a request the block raises a one-cycle abort pulse on either the data or the fetch side, together with a fault kind code. A data fault also stores an encoded status word, which carries the domain number, and the faulting virtual address. Software reads and writes the data-side and fetch-side status words through a small selector port. The fetch-side word is changed only by software.

Top module: `mmu_perm_guard`

## Requirements
- R1: For a mapped access whose domain access value is 0 or 2, the fault kind one cycle later is 1 (domain), whatever the AP bits, mode and direction are.
- R2: For a mapped access whose domain access value is 3, no fault is reported: fault kind 0, no abort pulse.
- R3: For domain access value 1, AP=1 faults every user-mode access, AP=2 faults user-mode writes only, and AP=3 allows all accesses. A permission fault is reported as fault kind 2.
- R4: For domain access value 1 and AP=0, the control bits (sys, rom) decide: (0,0) faults every access; (0,1) faults writes; (1,0) allows only privileged reads; (1,1) faults every access.
- R5: A section takes AP from descriptor bits [11:10]. A small page takes AP from descriptor bits [5+2n:4+2n], where n is virtual address bits [11:10].
- R6: The status word holds the fault code in bits [3:0]: section translation 5, page translation 7, section domain 9, page domain 11, section permission 13, page permission 15. Bits [7:4] hold the domain number for all of these except section translation, where they are 0. All upper bits are 0.
- R7: A faulting data access gives abort_d high for exactly the next cycle, with fault_kind set (0 none, 1 domain, 2 permission, 3 translation). At the same edge the data status word and fault_addr take the new status and the request's virtual address.
- R8: A faulting instruction fetch gives abort_p high for the next cycle and leaves the data status word, the fetch status word and fault_addr unchanged.
- R9: Software accesses the data status with sw_sel=0 and the fetch status with sw_sel=1. sw_rdata shows the selected word combinationally, and sw_wr loads sw_wdata into it at the clock edge. A data fault in the same cycle takes precedence over a software write to the data status.
- R10: After reset both status words and fault_addr read zero, both abort outputs are low and fault_kind is 0.
- R11: An unmapped access (req_unmapped=1) always reports fault kind 3 (translation), whatever the domain access value is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = privileged mode |
| req_page | input | 1 | 1 = small-page descriptor, 0 = section descriptor |
| req_unmapped | input | 1 | No valid descriptor was found (translation fault) |
| req_vaddr | input | 32 | Virtual address of the access |
| req_desc | input | 32 | Final descriptor word (section or small page) |
| req_domain | input | 4 | Domain number of the access |
| dom_access | input | 2 | Access value for that domain (0 none, 1 client, 2 reserved, 3 manager) |
| ctl_sys | input | 1 | System protection control bit |
| ctl_rom | input | 1 | ROM protection control bit |
| sw_wr | input | 1 | Software write strobe for a status word |
| sw_sel | input | 1 | Status word select: 0 data, 1 fetch |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected status word |
| abort_d | output | 1 | One-cycle data abort pulse |
| abort_p | output | 1 | One-cycle fetch abort pulse |
| fault_kind | output | 2 | Fault kind for the previous request |
| fault_addr | output | 32 | Virtual address of the last data fault |

## Verification
The checker module runs on every cycle. It checks that the two abort pulses never coincide, that a domain value of 0 or 2 always gives a domain fault, that a manager domain never gives a fault, that an unmapped access always gives a translation fault, that a data abort captures the address of the preceding request, and that a fetch leaves the fault address alone. Only the bench scenarios can show that the whole client AP and control-bit table is decoded correctly, that the right sub-page field is picked for each address, that each status code carries the right domain number, and that software writes are ordered against faults. The bench checks these against its own model through a scoreboard.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_DOMAIN = 2'd1,
      FK_PERM   = 2'd2,
      FK_XLAT   = 2'd3
   } fault_kind_e;

   typedef enum logic [1:0] {
      DA_NOACC   = 2'd0,
      DA_CLIENT  = 2'd1,
      DA_RESV    = 2'd2,
      DA_MANAGER = 2'd3
   } dom_acc_e;

   localparam int unsigned CODE_W = 4;

   // status code for a fault kind and descriptor size
   function automatic logic [CODE_W-1:0] fault_code(input fault_kind_e kind, input logic is_page);
      logic [CODE_W-1:0] c;
      unique case (kind)
         FK_XLAT:   c = is_page ? 4'd7  : 4'd5;
         FK_DOMAIN: c = is_page ? 4'd11 : 4'd9;
         FK_PERM:   c = is_page ? 4'd15 : 4'd13;
         default:   c = 4'd0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/mpg_ap_select.sv
module mpg_ap_select #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DESC_W   = 32,
   parameter int unsigned AP_W     = 2,
   parameter int unsigned SUBPAGES = 4,
   parameter int unsigned SEC_AP_LSB = 10,
   parameter int unsigned PG_AP_LSB  = 4,
   parameter int unsigned SUB_LSB    = 10
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [DESC_W-1:0] desc,
   input  logic              is_page,
   output logic [AP_W-1:0]   ap
);
   localparam int unsigned SEL_W = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1;

   logic [AP_W-1:0] sub_ap [SUBPAGES];
   logic [SEL_W-1:0] sub_idx;

   generate
      for (genvar n = 0; n < SUBPAGES; n++) begin : g_sub
         assign sub_ap[n] = desc[PG_AP_LSB + AP_W*n +: AP_W];
      end
   endgenerate

   assign sub_idx = vaddr[SUB_LSB +: SEL_W];

   always_comb begin
      if (is_page) ap = sub_ap[sub_idx];
      else         ap = desc[SEC_AP_LSB +: AP_W];
   end

endmodule

// File: rtl/mpg_decide.sv
module mpg_decide
   import mpg_pkg::*;
(
   input  logic [1:0]  dom_acc,
   input  logic [1:0]  ap,
   input  logic        ctl_sys,
   input  logic        ctl_rom,
   input  logic        user,
   input  logic        write,
   input  logic        unmapped,
   output fault_kind_e kind
);
   logic client_fault;

   // client domain: check the AP field against mode and direction
   always_comb begin
      unique case (ap)
         2'd0: begin
            unique case ({ctl_sys, ctl_rom})
               2'b00:   client_fault = 1'b1;
               2'b01:   client_fault = write;
               2'b10:   client_fault = user | write;
               default: client_fault = 1'b1;
            endcase
         end
         2'd1:    client_fault = user;
         2'd2:    client_fault = user & write;
         default: client_fault = 1'b0;
      endcase
   end

   always_comb begin
      if (unmapped) begin
         kind = FK_XLAT;
      end else begin
         unique case (dom_acc_e'(dom_acc))
            DA_CLIENT:  kind = client_fault ? FK_PERM : FK_NONE;
            DA_MANAGER: kind = FK_NONE;
            default:    kind = FK_DOMAIN;
         endcase
      end
   end

endmodule

// File: rtl/mpg_status_regs.sv
module mpg_status_regs
   import mpg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic              evt_fetch,
   input  fault_kind_e       evt_kind,
   input  logic [STAT_W-1:0] evt_status,
   input  logic [ADDR_W-1:0] evt_vaddr,
   input  logic              sw_wr,
   input  logic              sw_sel,
   input  logic [STAT_W-1:0] sw_wdata,
   output logic              abort_d,
   output logic              abort_p,
   output logic [1:0]        kind_q,
   output logic [STAT_W-1:0] dstat_q,
   output logic [STAT_W-1:0] pstat_q,
   output logic [ADDR_W-1:0] far_q
);
   logic is_fault, d_fault, p_fault;

   assign is_fault = evt_valid && (evt_kind != FK_NONE);
   assign d_fault  = is_fault && !evt_fetch;
   assign p_fault  = is_fault &&  evt_fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_d <= 1'b0;
         abort_p <= 1'b0;
         kind_q  <= FK_NONE;
      end else begin
         abort_d <= d_fault;
         abort_p <= p_fault;
         kind_q  <= evt_valid ? evt_kind : FK_NONE;
      end
   end

   // data side: a hardware fault wins over a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dstat_q <= '0;
         far_q   <= '0;
      end else if (d_fault) begin
         dstat_q <= evt_status;
         far_q   <= evt_vaddr;
      end else if (sw_wr && !sw_sel) begin
         dstat_q <= sw_wdata;
      end
   end

   // fetch side: written only by software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pstat_q <= '0;
      else if (sw_wr && sw_sel) pstat_q <= sw_wdata;
   end

endmodule

// File: rtl/mmu_perm_guard.sv
module mmu_perm_guard
   import mpg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DESC_W   = 32,
   parameter int unsigned DOM_W    = 4,
   parameter int unsigned STAT_W   = 32,
   parameter int unsigned SUBPAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_fetch,
   input  logic              req_write,
   input  logic              req_user,
   input  logic              req_page,
   input  logic              req_unmapped,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [DESC_W-1:0] req_desc,
   input  logic [DOM_W-1:0]  req_domain,
   input  logic [1:0]        dom_access,
   input  logic              ctl_sys,
   input  logic              ctl_rom,
   input  logic              sw_wr,
   input  logic              sw_sel,
   input  logic [STAT_W-1:0] sw_wdata,
   output logic [STAT_W-1:0] sw_rdata,
   output logic              abort_d,
   output logic              abort_p,
   output logic [1:0]        fault_kind,
   output logic [ADDR_W-1:0] fault_addr
);
   localparam int unsigned AP_W   = 2;
   localparam int unsigned PAD_W  = STAT_W - CODE_W - DOM_W;

   generate
      if (ADDR_W < 12)                       begin : g_bad_addr  $error("ADDR_W too small"); end
      if (DESC_W < 4 + AP_W*SUBPAGES)        begin : g_bad_desc  $error("DESC_W too small"); end
      if (STAT_W < CODE_W + DOM_W)           begin : g_bad_stat  $error("STAT_W too small"); end
      if (SUBPAGES != 4)                     begin : g_bad_sub   $error("SUBPAGES must be 4"); end
   endgenerate

   logic [AP_W-1:0]   ap;
   fault_kind_e       kind;
   logic [CODE_W-1:0] code;
   logic [DOM_W-1:0]  dom_field;
   logic [STAT_W-1:0] status;
   logic [STAT_W-1:0] dstat_q, pstat_q;

   mpg_ap_select #(
      .ADDR_W(ADDR_W), .DESC_W(DESC_W), .AP_W(AP_W), .SUBPAGES(SUBPAGES),
      .SEC_AP_LSB(10), .PG_AP_LSB(4), .SUB_LSB(10)
   ) i_ap (
      .vaddr(req_vaddr), .desc(req_desc), .is_page(req_page), .ap(ap)
   );

   mpg_decide i_dec (
      .dom_acc(dom_access), .ap(ap), .ctl_sys(ctl_sys), .ctl_rom(ctl_rom),
      .user(req_user), .write(req_write), .unmapped(req_unmapped), .kind(kind)
   );

   assign code      = fault_code(kind, req_page);
   assign dom_field = (kind == FK_XLAT && !req_page) ? '0 : req_domain;

   generate
      if (PAD_W > 0) begin : g_pad
         assign status = {{PAD_W{1'b0}}, dom_field, code};
      end else begin : g_nopad
         assign status = {dom_field, code};
      end
   endgenerate

   mpg_status_regs #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(req_valid), .evt_fetch(req_fetch), .evt_kind(kind),
      .evt_status(status), .evt_vaddr(req_vaddr),
      .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
      .abort_d(abort_d), .abort_p(abort_p), .kind_q(fault_kind),
      .dstat_q(dstat_q), .pstat_q(pstat_q), .far_q(fault_addr)
   );

   assign sw_rdata = sw_sel ? pstat_q : dstat_q;

endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_fetch,
   input logic              req_unmapped,
   input logic [ADDR_W-1:0] req_vaddr,
   input logic [1:0]        dom_access,
   input logic              abort_d,
   input logic              abort_p,
   input logic [1:0]        fault_kind,
   input logic [ADDR_W-1:0] fault_addr
);
   p_one_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({abort_d, abort_p}));

   p_domain_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_unmapped && (dom_access == 2'd0 || dom_access == 2'd2))
      |=> (fault_kind == 2'd1));

   p_manager_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_unmapped && dom_access == 2'd3)
      |=> (fault_kind == 2'd0 && !abort_d && !abort_p));

   p_xlat_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_unmapped) |=> (fault_kind == 2'd3));

   p_addr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_fetch) |=> (!abort_d || fault_addr == $past(req_vaddr)));

   p_fetch_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch) |=> ($stable(fault_addr) && !abort_d));

endmodule

bind mmu_perm_guard mpg_checker #(.ADDR_W(ADDR_W)) i_mpg_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
   .req_unmapped(req_unmapped), .req_vaddr(req_vaddr), .dom_access(dom_access),
   .abort_d(abort_d), .abort_p(abort_p), .fault_kind(fault_kind),
   .fault_addr(fault_addr)
);

// File: tb/test_mmu_perm_guard.sv
module test_mmu_perm_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_fetch = 0, req_write = 0, req_user = 0;
   logic req_page = 0, req_unmapped = 0;
   logic [31:0] req_vaddr = '0, req_desc = '0;
   logic [3:0]  req_domain = '0;
   logic [1:0]  dom_access = '0;
   logic ctl_sys = 0, ctl_rom = 0;
   logic sw_wr = 0, sw_sel = 0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;
   logic abort_d, abort_p;
   logic [1:0] fault_kind;
   logic [31:0] fault_addr;

   always #10 clk = ~clk;

   mmu_perm_guard i_mmu_perm_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
      .req_write(req_write), .req_user(req_user), .req_page(req_page),
      .req_unmapped(req_unmapped), .req_vaddr(req_vaddr), .req_desc(req_desc),
      .req_domain(req_domain), .dom_access(dom_access), .ctl_sys(ctl_sys),
      .ctl_rom(ctl_rom), .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .abort_d(abort_d), .abort_p(abort_p),
      .fault_kind(fault_kind), .fault_addr(fault_addr)
   );

   typedef struct {
      int          due;
      logic [1:0]  kind;
      logic        ad;
      logic        ap;
      logic [31:0] dstat;
      logic [31:0] faddr;
      string       tag;
   } item_t;

   item_t sb[$];
   int total = 0, bad = 0, cyc = 0;
   logic [31:0] m_dstat = '0, m_far = '0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // independent model of the decision
   function automatic logic [1:0] model_kind(input logic [1:0] da, input logic [1:0] ap,
         input logic s, input logic r, input logic u, input logic w, input logic unm);
      if (unm) return 2'd3;
      if (da == 2'd3) return 2'd0;
      if (da != 2'd1) return 2'd1;
      if (ap == 2'd3) return 2'd0;
      if (ap == 2'd2) return (u && w) ? 2'd2 : 2'd0;
      if (ap == 2'd1) return u ? 2'd2 : 2'd0;
      if (!s && !r) return 2'd2;
      if (!s &&  r) return w ? 2'd2 : 2'd0;
      if ( s && !r) return (u || w) ? 2'd2 : 2'd0;
      return 2'd2;
   endfunction

   task automatic issue(input string tag, input logic fe, input logic w, input logic u,
         input logic pg, input logic unm, input logic [31:0] va, input logic [31:0] de,
         input logic [3:0] dm, input logic [1:0] da, input logic s, input logic r);
      item_t it;
      logic [1:0] ap, k;
      logic [3:0] code;
      logic [31:0] st;
      @(posedge clk); #2;
      req_valid = 1; req_fetch = fe; req_write = w; req_user = u; req_page = pg;
      req_unmapped = unm; req_vaddr = va; req_desc = de; req_domain = dm;
      dom_access = da; ctl_sys = s; ctl_rom = r;
      ap = pg ? 2'((de >> (4 + 2*va[11:10])) & 32'h3) : de[11:10];
      k = model_kind(da, ap, s, r, u, w, unm);
      case (k)
         2'd1: code = pg ? 4'd11 : 4'd9;
         2'd2: code = pg ? 4'd15 : 4'd13;
         2'd3: code = pg ? 4'd7 : 4'd5;
         default: code = 4'd0;
      endcase
      st = {24'd0, (k == 2'd3 && !pg) ? 4'd0 : dm, code};
      if (k != 2'd0 && !fe) begin m_dstat = st; m_far = va; end
      it.due = cyc + 1; it.kind = k; it.ad = (k != 0) && !fe; it.ap = (k != 0) && fe;
      it.dstat = m_dstat; it.faddr = m_far; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input string tag);
      item_t it;
      @(posedge clk); #2;
      req_valid = 0;
      it.due = cyc + 1; it.kind = 0; it.ad = 0; it.ap = 0;
      it.dstat = m_dstat; it.faddr = m_far; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare at the falling edge after the registering edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         check(it.tag, "fault_kind", 32'(fault_kind), 32'(it.kind));
         check(it.tag, "abort_d",    32'(abort_d),    32'(it.ad));
         check(it.tag, "abort_p",    32'(abort_p),    32'(it.ap));
         check(it.tag, "data_status", sw_rdata,       it.dstat);
         check(it.tag, "fault_addr", fault_addr,      it.faddr);
      end
   end

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R10 reset state
      check("R10", "abort_d", 32'(abort_d), 0);
      check("R10", "abort_p", 32'(abort_p), 0);
      check("R10", "fault_kind", 32'(fault_kind), 0);
      check("R10", "fault_addr", fault_addr, 0);
      check("R10", "data_status", sw_rdata, 0);
      sw_sel = 1; #1;
      check("R10", "fetch_status", sw_rdata, 0);
      sw_sel = 0;

      // R1 R2 R3 R4: full sweep over sections (AP at bits 11:10, R5)
      for (int da = 0; da < 4; da++)
         for (int ap = 0; ap < 4; ap++)
            for (int sr = 0; sr < 4; sr++)
               for (int uw = 0; uw < 4; uw++) begin
                  string t;
                  t = (da == 1) ? ((ap == 0) ? "R4" : "R3") : ((da == 3) ? "R2" : "R1");
                  issue(t, 0, uw[0], uw[1], 0, 0, 32'h0010_0000 + 32'(da*64 + ap*16 + sr*4 + uw),
                        (32'hFFF0_F3FF & 32'hFFFF_F3FF) | (32'(ap) << 10),
                        4'(da*4 + ap), 2'(da), sr[1], sr[0]);
               end
      idle("R7");

      // R5 R6: small pages, four distinct sub-page fields, each selected by vaddr[11:10]
      for (int n = 0; n < 4; n++) begin
         // fields: n0=3, n1=1, n2=2, n3=0 -> desc bits [11:4] = 8'b00_10_01_11
         issue("R5", 0, 0, 1, 1, 0, 32'h2000_0000 | (32'(n) << 10), 32'h0000_0270, 4'd5, 2'd1, 0, 0);
         issue("R5", 0, 1, 1, 1, 0, 32'h2000_0000 | (32'(n) << 10), 32'h0000_0270, 4'd6, 2'd1, 0, 1);
      end
      issue("R6", 0, 0, 0, 1, 0, 32'h3000_0400, 32'h0, 4'd12, 2'd0, 0, 0);
      idle("R7");
      // R11 translation faults: section (domain bits 0) and page (domain kept)
      issue("R11", 0, 0, 0, 0, 1, 32'h4000_0000, 32'h0, 4'd9, 2'd3, 0, 0);
      issue("R11", 0, 1, 1, 1, 1, 32'h4000_1000, 32'h0, 4'd10, 2'd1, 0, 0);
      idle("R6");
      // R8 fetch faults keep data state
      issue("R8", 1, 0, 1, 0, 0, 32'h5000_0000, 32'h0000_0400, 4'd3, 2'd1, 0, 0);
      issue("R8", 1, 0, 0, 0, 1, 32'h5000_0004, 32'h0, 4'd3, 2'd1, 0, 0);
      issue("R8", 1, 0, 0, 1, 0, 32'h5000_0008, 32'h0, 4'd2, 2'd0, 0, 0);
      idle("R8");
      drain();
      // R8: fetch status untouched by fetch faults
      sw_sel = 1; #1;
      check("R8", "fetch_status", sw_rdata, 0);
      sw_sel = 0;

      // R9 software write of fetch status, data status unchanged
      @(posedge clk); #2; sw_wr = 1; sw_sel = 1; sw_wdata = 32'hA5A5_0001;
      @(posedge clk); #2; sw_wr = 0;
      check("R9", "fetch_status", sw_rdata, 32'hA5A5_0001);
      sw_sel = 0; #1;
      check("R9", "data_status", sw_rdata, m_dstat);
      // R9 software write of data status
      @(posedge clk); #2; sw_wr = 1; sw_sel = 0; sw_wdata = 32'h0000_0C3C;
      @(posedge clk); #2; sw_wr = 0; m_dstat = 32'h0000_0C3C;
      check("R9", "data_status", sw_rdata, 32'h0000_0C3C);
      // R9 fault and software write in the same cycle: fault wins
      sw_wr = 1; sw_wdata = 32'hDEAD_BEEF;
      issue("R9", 0, 1, 1, 0, 0, 32'h6000_0010, 32'h0000_0800, 4'd7, 2'd1, 0, 0);
      @(posedge clk); #2; sw_wr = 0; req_valid = 0;
      drain();
      check("R9", "data_status", sw_rdata, {24'd0, 4'd7, 4'd13});
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule